// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block produces the serial clock of an SPI master from the module clock. A single configuration word carries two divider fields and a mode bit that picks the law. In linear mode the serial clock runs at module clock / (2·(N+1)). In exponent mode it runs at module clock / 2^(E+1). Alongside the clock the block gives two strobes, each one module-clock cycle wide. A shift engine in the same clock domain uses them to shift and sample data without looking at the clock pin itself.

The output clock is registered and always keeps a 50% duty cycle. A change to the setting is taken at the end of the current serial period, when the clock is back at its idle level, so no short pulse reaches the pin. While the enable is low the clock sits at the level set by the polarity input and neither strobe fires. The shift register, the FIFOs and chip-select handling live elsewhere.

Top module: `spi_sclk_divider`

## Requirements
- R1: With cfg_word[12] = 1 (linear mode), the serial period is 2·(N+1) module-clock cycles, where N = cfg_word[7:0]; the clock leaves idle N+1 cycles into each period and returns to idle at its end.
- R2: With cfg_word[12] = 0 (exponent mode), the serial period is 2^(E+1) module-clock cycles, where E = cfg_word[11:8].
- R3: Linear mode with N = 0 gives the fastest rate: sclk changes level on every enabled module-clock edge.
- R4: In every setting of both modes, sclk spends exactly half of each period away from idle and half at idle.
- R5: A new cfg_word value has no effect until the current period ends; it is sampled on the edge where sclk returns to idle, and the next period uses it.
- R6: While en is low, sclk equals cpol on the following edge and stays there, and neither strobe is asserted; dropping en mid-period returns sclk to idle on the next edge.
- R7: rise_stb is high for exactly the one cycle in which sclk first reads 1 after reading 0 while enabled, and fall_stb likewise for the first cycle at 0 after 1; the two are never high together.
- R8: The setting is sampled on the first edge that sees en high, and with half period H the first transition away from idle appears on the H-th enabled edge, counting that first edge as 1.
- R9: While rst_n is low, sclk follows cpol and both strobes are low on each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word | input | 13 | [7:0] linear count N, [11:8] exponent E, [12] mode (1 linear, 0 exponent) |
| en | input | 1 | Run the serial clock when high |
| cpol | input | 1 | Idle level of sclk |
| sclk | output | 1 | Divided serial clock |
| rise_stb | output | 1 | One-cycle strobe in the first cycle sclk is high |
| fall_stb | output | 1 | One-cycle strobe in the first cycle sclk is low |

## Verification
The assertions assume that cpol only changes while en is low. A polarity flip during a run would move the clock with no strobe, and the alignment properties would then not hold. cfg_word may change at any time. The bench therefore draws random settings and random mid-run changes of cfg_word and en freely, but it writes cpol only while the block is disabled. Exponent values in the random runs are kept small so the runs stay short; the largest exponent is covered in a single directed run.

// File: rtl/sclk_div_pkg.sv
// Shared types and helpers for the serial clock divider.
// Assumes nothing beyond elaboration-time constant arguments.
package sclk_div_pkg;

    // Divider law chosen by the mode bit of the configuration word.
    typedef enum logic {
        LAW_EXPONENT = 1'b0,
        LAW_LINEAR   = 1'b1
    } div_law_e;

    // Larger of two widths, used to size the terminal counter.
    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sclk_div_law.sv
// Turns the divider fields and the law into a terminal count equal to
// half the serial period minus one, in module-clock cycles.
// Assumes TERM_W holds both LIN_W bits and 2^EXP_W - 1 bits.
module sclk_div_law
    import sclk_div_pkg::*;
#(
    parameter int LIN_W  = 8,
    parameter int EXP_W  = 4,
    parameter int TERM_W = 15
) (
    input  logic [LIN_W-1:0]  lin_n,
    input  logic [EXP_W-1:0]  exp_n,
    input  div_law_e          law,
    output logic [TERM_W-1:0] term
);

    logic [TERM_W-1:0] exp_mask;

    // Build 2^E - 1 as a run of E low ones.
    always_comb begin
        for (int i = 0; i < TERM_W; i++) begin
            exp_mask[i] = (i < int'(exp_n));
        end
    end

    // Pick the half-period terminal count for the selected law.
    always_comb begin
        if (law == LAW_LINEAR) begin
            term = TERM_W'(lin_n);
        end else begin
            term = exp_mask;
        end
    end

endmodule

// File: rtl/sclk_div_core.sv
// Counts module-clock cycles up to the active terminal count, toggles the
// serial clock phase at each terminal hit and emits edge strobes.
// The active count is reloaded only on the edge that ends a full period.
// Assumes cpol is held constant while en is high.
module sclk_div_core #(
    parameter int TERM_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic [TERM_W-1:0] term_new,
    output logic              sclk,
    output logic              rise_stb,
    output logic              fall_stb
);

    logic              run_q;
    logic              phase_q;
    logic              phase_d;
    logic              hit;
    logic              lvl_d;
    logic              load_term;
    logic [TERM_W-1:0] cnt_q;
    logic [TERM_W-1:0] term_q;
    logic [TERM_W-1:0] term_use;

    // Decide terminal hit, next phase and whether to take a new setting.
    always_comb begin
        term_use  = run_q ? term_q : term_new;
        hit       = (cnt_q == term_use);
        phase_d   = phase_q ^ hit;
        lvl_d     = cpol ^ phase_d;
        load_term = !run_q || (hit && phase_q);
    end

    // Run flag, half-period counter and phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            run_q   <= 1'b1;
            cnt_q   <= hit ? '0 : cnt_q + TERM_W'(1);
            phase_q <= phase_d;
        end
    end

    // Active setting, refreshed while idle or at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q <= '0;
        end else if (!en || load_term) begin
            term_q <= term_new;
        end
    end

    // Registered clock level and edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sclk     <= cpol;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            sclk     <= lvl_d;
            rise_stb <= hit && lvl_d;
            fall_stb <= hit && !lvl_d;
        end
    end

    AST_RISE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (sclk && !$past(sclk))); // R7
    AST_FALL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!sclk && $past(sclk))); // R7
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb)); // R7
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((sclk == $past(cpol)) && !rise_stb && !fall_stb)); // R6
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run_q && (cnt_q != term_q)) |=> $stable(phase_q)); // R4
    AST_SETTING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run_q && !(hit && phase_q)) |=> $stable(term_q)); // R5
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= term_q)); // R1

endmodule

// File: rtl/spi_sclk_divider.sv
// Top of the dual-law serial clock divider: splits the configuration word
// into its fields, converts them to a terminal count and drives the core.
// Assumes cfg_word may change at any time; cpol changes only while idle.
module spi_sclk_divider
    import sclk_div_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LIN_W+EXP_W:0]   cfg_word,
    input  logic                   en,
    input  logic                   cpol,
    output logic                   sclk,
    output logic                   rise_stb,
    output logic                   fall_stb
);

    localparam int TERM_W   = int'(max_of((1 << EXP_W) - 1, LIN_W));
    localparam int LAW_BIT  = LIN_W + EXP_W;

    logic [LIN_W-1:0]  lin_n;
    logic [EXP_W-1:0]  exp_n;
    div_law_e          law;
    logic [TERM_W-1:0] term_new;

    // Field split of the configuration word.
    always_comb begin
        lin_n = cfg_word[LIN_W-1:0];
        exp_n = cfg_word[LIN_W +: EXP_W];
        law   = div_law_e'(cfg_word[LAW_BIT]);
    end

    sclk_div_law #(
        .LIN_W (LIN_W),
        .EXP_W (EXP_W),
        .TERM_W(TERM_W)
    ) law_i (
        .lin_n(lin_n),
        .exp_n(exp_n),
        .law  (law),
        .term (term_new)
    );

    sclk_div_core #(
        .TERM_W(TERM_W)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .cpol    (cpol),
        .term_new(term_new),
        .sclk    (sclk),
        .rise_stb(rise_stb),
        .fall_stb(fall_stb)
    );

endmodule

// File: tb/spi_sclk_divider_tb.sv
// Self-checking bench: a cycle model built from the requirements runs
// beside the divider and is compared after every module-clock edge.
module spi_sclk_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] cfg_word;
    logic        en;
    logic        cpol;
    logic        sclk;
    logic        rise_stb;
    logic        fall_stb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int m_k, m_h;
    bit m_run, m_lvl;
    int step_no, rise_cnt, fall_cnt, high_cnt, first_rise;

    always #10 clk = ~clk;

    spi_sclk_divider dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_word(cfg_word),
        .en      (en),
        .cpol    (cpol),
        .sclk    (sclk),
        .rise_stb(rise_stb),
        .fall_stb(fall_stb)
    );

    function automatic int half_of(input logic [12:0] w);
        return w[12] ? int'(w[7:0]) + 1 : (1 << w[11:8]);
    endfunction

    function automatic logic [12:0] lin_cfg(input int n);
        return {1'b1, 4'd0, 8'(n)};
    endfunction

    function automatic logic [12:0] exp_cfg(input int e);
        return {1'b0, 4'(e), 8'd0};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at step %0d: actual %0d expected %0d", tag, what, step_no, act, exp);
        end
    endtask

    // One module-clock edge: advance the model, then compare at the falling edge.
    task automatic step(input string tag);
        bit nl, er, ef;
        @(posedge clk);
        if (!en) begin
            m_run = 1'b0;
            m_k   = 0;
            nl    = cpol;
        end else begin
            if (!m_run) begin
                m_run = 1'b1;
                m_h   = half_of(cfg_word);
                m_k   = 0;
            end
            m_k++;
            nl = cpol ^ ((m_k >= m_h) && (m_k < 2 * m_h));
            if (m_k == 2 * m_h) begin
                m_k = 0;
                m_h = half_of(cfg_word);
            end
        end
        er    = en && nl && !m_lvl;
        ef    = en && !nl && m_lvl;
        m_lvl = nl;
        @(negedge clk);
        step_no++;
        check(tag, "sclk/rise/fall", int'({sclk, rise_stb, fall_stb}), int'({nl, er, ef}));
        if (rise_stb) begin
            rise_cnt++;
            if (first_rise < 0) first_rise = step_no;
        end
        if (fall_stb) fall_cnt++;
        if (sclk) high_cnt++;
    endtask

    task automatic clear_stats();
        step_no = 0; rise_cnt = 0; fall_cnt = 0; high_cnt = 0; first_rise = -1;
    endtask

    // Idle two edges with new polarity and setting, then run n enabled edges.
    task automatic run(input string tag, input logic [12:0] w, input bit pol, input int n);
        en = 1'b0;
        @(negedge clk);
        cpol     = pol;
        cfg_word = w;
        step(tag);
        step(tag);
        clear_stats();
        en = 1'b1;
        repeat (n) step(tag);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd4417));
        rst_n = 1'b0; en = 1'b0; cpol = 1'b0; cfg_word = lin_cfg(0);
        clear_stats();
        repeat (3) @(negedge clk);
        check("R9", "sclk in reset", int'({sclk, rise_stb, fall_stb}), 0);
        cpol = 1'b1;
        en   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9", "sclk in reset cpol1", int'({sclk, rise_stb, fall_stb}), 4);
        en = 1'b0; cpol = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_lvl = 1'b0; m_run = 1'b0; m_k = 0; m_h = 1;

        // Fastest linear rate.
        run("R3", lin_cfg(0), 1'b0, 12);
        check("R3", "rise count", rise_cnt, 6);
        // Linear laws, both polarities.
        run("R1", lin_cfg(5), 1'b1, 48);
        run("R1", lin_cfg(255), 1'b0, 1100);
        check("R1", "first rise N=255", first_rise, 256);
        // Exponent laws.
        run("R2", exp_cfg(0), 1'b0, 10);
        run("R2", exp_cfg(3), 1'b1, 64);
        run("R2", exp_cfg(15), 1'b0, 32770);
        check("R2", "first rise E=15", first_rise, 32768);
        // Duty cycle and strobe counts over ten full periods.
        run("R4", lin_cfg(2), 1'b0, 60);
        check("R4", "high cycles", high_cnt, 30);
        check("R7", "rise strobes", rise_cnt, 10);
        check("R7", "fall strobes", fall_cnt, 10);
        // First transition timing.
        run("R8", lin_cfg(6), 1'b0, 20);
        check("R8", "first rise step", first_rise, 7);
        // Setting change in the active half and in the idle half.
        run("R5", lin_cfg(3), 1'b0, 6);
        cfg_word = lin_cfg(1);
        repeat (30) step("R5");
        cfg_word = exp_cfg(2);
        step("R5");
        cfg_word = lin_cfg(0);
        repeat (30) step("R5");
        // Disable mid-period with idle-high polarity, then stay idle.
        run("R6", lin_cfg(4), 1'b1, 7);
        en = 1'b0;
        clear_stats();
        repeat (20) step("R6");
        check("R6", "strobes while idle", rise_cnt + fall_cnt, 0);
        check("R6", "idle high samples", high_cnt, 20);

        // Random runs with mid-run setting changes and aborts.
        for (int r = 0; r < 40; r++) begin
            logic [12:0] w;
            int n;
            string tag;
            w   = ($urandom % 2) ? lin_cfg($urandom % 16) : exp_cfg($urandom % 5);
            tag = w[12] ? "R1" : "R2";
            n   = 20 + ($urandom % 130);
            run(tag, w, 1'($urandom % 2), n / 2);
            if (($urandom % 10) < 3) begin
                cfg_word = ($urandom % 2) ? lin_cfg($urandom % 16) : exp_cfg($urandom % 5);
                tag = "R5";
            end
            if (($urandom % 10) < 2) begin
                en  = 1'b0;
                tag = "R6";
            end
            repeat (n - n / 2) step(tag);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule